// File: doc/BRIEF.md
# Stereo Audio Sample Burst Packer

This block sits between a digital audio receiver and the memory system. Every cycle in which `in_valid` is high it takes one stereo frame, a left sample and a right sample. It packs the frame into 32-bit memory words according to a sample format and a byte order chosen at its inputs. The words collect in one of two burst buffers. When a buffer holds a full 64-byte burst, the block raises a write request and keeps filling the other buffer. The write side sees a whole burst at once: the data, a target address and a request held until the acknowledge arrives.

The write address starts at a base and advances by one burst size after each accepted burst. It returns to the base after a programmed number of bursts, so the memory region works as a ring. The memory side may fall behind until both buffers are full. In that case any further frame is thrown away, and a sticky bandwidth-error flag is raised. The flag stays set until software pulses the clear input. A dropped frame is never replayed.

Top module: `sdp_packer`

## Requirements
- R1: After reset, `wr_req` is 0, `bw_err` is 0, and `wr_addr` equals `base_addr`.
- R2: With `fmt_sel` = 2'b01 or 2'b11 (32-bit stereo), each frame fills two consecutive words: the left sample at the even word position of the burst and the right sample in the next one.
- R3: With `fmt_sel` = 2'b00 (16-bit stereo), each frame fills one word: bits 15:0 hold `in_left[15:0]` and bits 31:16 hold `in_right[15:0]`, before any byte reordering.
- R4: With `big_end` = 0, a word is stored as formed. With `big_end` = 1, in the 16-bit and 32-bit stereo formats the four bytes of each word are reversed: byte 0 goes to bits 31:24, byte 1 to bits 23:16, byte 2 to bits 15:8 and byte 3 to bits 7:0.
- R5: With `fmt_sel` = 2'b10 (raw), the left and right inputs are stored as two words in the same way as R2, unchanged whatever the value of `big_end`.
- R6: A burst is 16 words (64 bytes). Word i of the burst is at `wr_data[32*i+31:32*i]`, and word 0 is the first one filled. `wr_req` rises on the clock edge that stores the last word of a burst. `wr_req`, `wr_data` and `wr_addr` hold until `wr_ack` is sampled high while `wr_req` is high.
- R7: Two burst buffers alternate. While one full burst waits for acknowledge, frames fill the other buffer. Bursts are presented in the order they were filled.
- R8: The burst with k accepted bursts before it is written at `base_addr` + 64*k', where k' is k modulo `region_bursts`. A `region_bursts` of 0 behaves as 1.
- R9: A frame that arrives when the buffer it would fill is still full is dropped. It leaves the stored bursts untouched, and `bw_err` reads 1 from the next cycle. An acknowledge in the same cycle does not save the frame.
- R10: `bw_err` stays 1 until a cycle with `err_clr` high, after which it reads 0. If a frame is dropped in that same cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A stereo frame is present this cycle |
| in_left | input | 32 | Left sample or subframe word |
| in_right | input | 32 | Right sample or subframe word |
| fmt_sel | input | 2 | 00 16-bit stereo, 01/11 32-bit stereo, 10 raw |
| big_end | input | 1 | 1 selects reversed byte order within each word |
| base_addr | input | ADDR_W (32) | Start address of the ring region |
| region_bursts | input | IDX_W (12) | Number of bursts in the ring region |
| err_clr | input | 1 | Pulse that clears the bandwidth-error flag |
| wr_req | output | 1 | A full burst is waiting to be written |
| wr_addr | output | ADDR_W (32) | Address of the waiting burst |
| wr_data | output | WORDS*32 (512) | The waiting burst, word 0 in the low bits |
| wr_ack | input | 1 | The memory side accepts the waiting burst |
| bw_err | output | 1 | Sticky bandwidth-error flag |

## Verification
The bench runs every format code that matters (16-bit, 32-bit and raw) with each byte order. Each run streams frames whose left and right values are distinct arithmetic sequences, so a swapped channel, a misplaced half-word, a wrong byte order or a byte swap wrongly applied in raw mode gives a different word. Five bursts per run in a three-burst region show that addresses advance and then return to the base. A separate run holds off the acknowledge until both buffers fill. That run shows the two waiting bursts are kept intact while a later frame is dropped, and it covers the sticky flag, its clear and a clear that arrives in the same cycle as a drop.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    typedef enum logic [1:0] {
        FMT_S16  = 2'b00,
        FMT_S32  = 2'b01,
        FMT_RAW  = 2'b10,
        FMT_S32B = 2'b11
    } fmt_e;

    function automatic logic [31:0] byte_rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/sdp_word_fmt.sv
module sdp_word_fmt
    import sdp_pkg::*;
(
    input  logic [1:0]  fmt_sel,
    input  logic        big_end,
    input  logic [31:0] in_left,
    input  logic [31:0] in_right,
    output logic [31:0] word0,
    output logic [31:0] word1,
    output logic        two_words
);

    fmt_e        fmt;
    logic [31:0] raw0;
    logic [31:0] raw1;
    logic        do_swap;

    always_comb begin
        fmt       = fmt_e'(fmt_sel);
        two_words = 1'b1;
        do_swap   = big_end;
        raw0      = in_left;
        raw1      = in_right;
        case (fmt)
            FMT_S16: begin
                raw0      = {in_right[15:0], in_left[15:0]};
                raw1      = '0;
                two_words = 1'b0;
            end
            FMT_RAW: begin
                do_swap = 1'b0;
            end
            default: begin
                raw0 = in_left;
                raw1 = in_right;
            end
        endcase
        word0 = do_swap ? byte_rev(raw0) : raw0;
        word1 = do_swap ? byte_rev(raw1) : raw1;
    end

endmodule

// File: rtl/sdp_pingpong.sv
module sdp_pingpong #(
    parameter int WORDS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [31:0]        word0,
    input  logic [31:0]        word1,
    input  logic               two_words,
    input  logic               wr_ack,
    output logic               wr_req,
    output logic [WORDS*32-1:0] wr_data,
    output logic               fire,
    output logic               drop
);

    localparam int CW = $clog2(WORDS);

    typedef struct packed {
        logic [1:0][WORDS-1:0][31:0] mem;
        logic [1:0]                  full;
        logic                        fb;
        logic                        db;
        logic [CW-1:0]               wc;
    } pp_st_t;

    pp_st_t      st_d, st_q;
    logic [CW:0] nwc;

    always_comb begin
        st_d = st_q;
        drop = 1'b0;
        nwc  = '0;
        if (in_valid) begin
            if (st_q.full[st_q.fb]) begin
                drop = 1'b1;
            end else begin
                st_d.mem[st_q.fb][st_q.wc] = word0;
                if (two_words) begin
                    st_d.mem[st_q.fb][st_q.wc + 1'b1] = word1;
                    nwc = {1'b0, st_q.wc} + (CW+1)'(2);
                end else begin
                    nwc = {1'b0, st_q.wc} + (CW+1)'(1);
                end
                if (nwc == (CW+1)'(WORDS)) begin
                    st_d.full[st_q.fb] = 1'b1;
                    st_d.fb            = ~st_q.fb;
                    st_d.wc            = '0;
                end else begin
                    st_d.wc = nwc[CW-1:0];
                end
            end
        end
        if (wr_ack && st_q.full[st_q.db]) begin
            st_d.full[st_q.db] = 1'b0;
            st_d.db            = ~st_q.db;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_req  = st_q.full[st_q.db];
    assign wr_data = st_q.mem[st_q.db];
    assign fire    = wr_req & wr_ack;

endmodule

// File: rtl/sdp_addr_gen.sv
module sdp_addr_gen #(
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = 12,
    parameter int BURST_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [IDX_W-1:0]  region_bursts,
    output logic [ADDR_W-1:0] wr_addr
);

    localparam int SH = $clog2(BURST_BYTES);

    logic [IDX_W-1:0] idx_d, idx_q;
    logic [IDX_W:0]   nxt;

    always_comb begin
        idx_d = idx_q;
        nxt   = {1'b0, idx_q} + (IDX_W+1)'(1);
        if (fire) begin
            if (nxt >= {1'b0, region_bursts}) begin
                idx_d = '0;
            end else begin
                idx_d = nxt[IDX_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign wr_addr = base_addr + (ADDR_W'(idx_q) << SH);

endmodule

// File: rtl/sdp_packer.sv
module sdp_packer #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 12,
    parameter int WORDS  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [31:0]         in_left,
    input  logic [31:0]         in_right,
    input  logic [1:0]          fmt_sel,
    input  logic                big_end,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [IDX_W-1:0]    region_bursts,
    input  logic                err_clr,
    output logic                wr_req,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [WORDS*32-1:0] wr_data,
    input  logic                wr_ack,
    output logic                bw_err
);

    localparam int BURST_BYTES = WORDS * 4;

    logic [31:0] word0;
    logic [31:0] word1;
    logic        two_words;
    logic        fire;
    logic        drop;
    logic        err_d, err_q;

    sdp_word_fmt u_fmt (
        .fmt_sel   (fmt_sel),
        .big_end   (big_end),
        .in_left   (in_left),
        .in_right  (in_right),
        .word0     (word0),
        .word1     (word1),
        .two_words (two_words)
    );

    sdp_pingpong #(.WORDS(WORDS)) u_pp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .word0     (word0),
        .word1     (word1),
        .two_words (two_words),
        .wr_ack    (wr_ack),
        .wr_req    (wr_req),
        .wr_data   (wr_data),
        .fire      (fire),
        .drop      (drop)
    );

    sdp_addr_gen #(
        .ADDR_W      (ADDR_W),
        .IDX_W       (IDX_W),
        .BURST_BYTES (BURST_BYTES)
    ) u_addr (
        .clk           (clk),
        .rst_n         (rst_n),
        .fire          (fire),
        .base_addr     (base_addr),
        .region_bursts (region_bursts),
        .wr_addr       (wr_addr)
    );

    always_comb begin
        err_d = err_q;
        if (err_clr) err_d = 1'b0;
        if (drop)    err_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_d;
        end
    end

    assign bw_err = err_q;

endmodule

// File: rtl/sdp_packer_chk.sv
module sdp_packer_chk #(
    parameter int ADDR_W = 32,
    parameter int WORDS  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [ADDR_W-1:0]   base_addr,
    input logic                err_clr,
    input logic                wr_req,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [WORDS*32-1:0] wr_data,
    input logic                wr_ack,
    input logic                bw_err
);

    localparam int SH = $clog2(WORDS * 4);

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_ack |=> wr_req && $stable(wr_data));

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_ack |=> $stable(wr_addr) || !$stable(base_addr));

    // R8
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> wr_addr[SH-1:0] == base_addr[SH-1:0]);

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bw_err) |-> $past(in_valid));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bw_err && !err_clr |=> bw_err);

    // R10
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !in_valid |=> !bw_err);

endmodule

bind sdp_packer sdp_packer_chk #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .base_addr (base_addr),
    .err_clr   (err_clr),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_ack    (wr_ack),
    .bw_err    (bw_err)
);

// File: tb/tb_sdp_packer.sv
module tb_sdp_packer;

    localparam int WORDS  = 16;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 12;
    localparam logic [31:0] BASE = 32'h8000_1240;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [31:0]         in_left = '0;
    logic [31:0]         in_right = '0;
    logic [1:0]          fmt_sel = 2'b01;
    logic                big_end = 1'b0;
    logic [ADDR_W-1:0]   base_addr = BASE;
    logic [IDX_W-1:0]    region_bursts = 12'd3;
    logic                err_clr = 1'b0;
    logic                wr_req;
    logic [ADDR_W-1:0]   wr_addr;
    logic [WORDS*32-1:0] wr_data;
    logic                wr_ack = 1'b0;
    logic                bw_err;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    sdp_packer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORDS(WORDS)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .fmt_sel(fmt_sel), .big_end(big_end),
        .base_addr(base_addr), .region_bursts(region_bursts), .err_clr(err_clr),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .bw_err(bw_err)
    );

    function automatic logic [31:0] lval(int n);
        return 32'hA000_0000 ^ (32'(n) * 32'h0102_0407);
    endfunction

    function automatic logic [31:0] rval(int n);
        return (32'h5000_0011 + 32'(n) * 32'h0003_0109) ^ 32'h00FF_0000;
    endfunction

    function automatic logic [31:0] rev(logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [WORDS*32-1:0] exp_burst(logic [1:0] m, logic be, int f0);
        logic [WORDS*32-1:0] r;
        logic [31:0] w, l, rr;
        r = '0;
        for (int j = 0; j < WORDS; j++) begin
            if (m == 2'b00) begin
                l  = lval(f0 + j);
                rr = rval(f0 + j);
                w  = {rr[15:0], l[15:0]};
            end else begin
                w = (j % 2 == 0) ? lval(f0 + j / 2) : rval(f0 + j / 2);
            end
            if (be && m != 2'b10) w = rev(w);
            r[j*32 +: 32] = w;
        end
        return r;
    endfunction

    task automatic chk(bit ok, string tag, logic [WORDS*32-1:0] act, logic [WORDS*32-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic feed_frame(int n, bit clr);
        @(negedge clk);
        in_valid = 1'b1;
        in_left  = lval(n);
        in_right = rval(n);
        err_clr  = clr;
        @(negedge clk);
        in_valid = 1'b0;
        err_clr  = 1'b0;
    endtask

    task automatic drain_one(logic [WORDS*32-1:0] ed, logic [31:0] ea, string tag);
        forever begin
            @(negedge clk);
            if (wr_req) break;
        end
        chk(wr_data == ed, {tag, " R6 burst data"}, wr_data, ed);
        chk(wr_addr == ea, "R8 burst address", WORDS*32'(wr_addr), WORDS*32'(ea));
        wr_ack = 1'b1;
        @(negedge clk);
        wr_ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int m = 0; m < 3; m++) begin
            for (int be = 0; be < 2; be++) begin
                string tag;
                int    fpb;
                fmt_sel = 2'(m);
                big_end = 1'(be);
                do_reset();
                // R1 reset state
                chk(!wr_req && !bw_err && wr_addr == BASE, "R1 reset state",
                    WORDS*32'({wr_req, bw_err, wr_addr}), WORDS*32'({2'b00, BASE}));
                if (be != 0) tag = (m == 2) ? "R5" : "R4";
                else         tag = (m == 0) ? "R3" : "R2";
                fpb = (m == 0) ? WORDS : WORDS / 2;
                fork
                    begin
                        for (int n = 0; n < 5 * fpb; n++) begin
                            feed_frame(n, 1'b0);
                            repeat (2) @(negedge clk);
                        end
                    end
                    begin
                        for (int b = 0; b < 5; b++)
                            drain_one(exp_burst(2'(m), 1'(be), b * fpb),
                                      BASE + 32'(64 * (b % 3)), tag);
                    end
                join
                chk(!bw_err, "R9 no drop at sustained rate", WORDS*32'(bw_err), '0);
            end
        end

        // overflow run: 32-bit stereo, little endian, no acknowledge
        fmt_sel = 2'b01;
        big_end = 1'b0;
        do_reset();
        for (int n = 0; n < 16; n++) feed_frame(n, 1'b0);
        // R7 both buffers hold a burst, nothing dropped yet
        chk(wr_req && !bw_err, "R7 two bursts held",
            WORDS*32'({wr_req, bw_err}), WORDS*32'(2'b10));
        feed_frame(16, 1'b0);
        chk(bw_err, "R9 drop sets flag", WORDS*32'(bw_err), WORDS*32'(1));
        repeat (3) @(negedge clk);
        chk(bw_err, "R10 flag sticky", WORDS*32'(bw_err), WORDS*32'(1));
        feed_frame(17, 1'b1);
        chk(bw_err, "R10 drop beats clear", WORDS*32'(bw_err), WORDS*32'(1));
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(!bw_err, "R10 clear", WORDS*32'(bw_err), '0);
        feed_frame(18, 1'b0);
        chk(bw_err, "R9 drop sets flag again", WORDS*32'(bw_err), WORDS*32'(1));
        drain_one(exp_burst(2'b01, 1'b0, 0), BASE, "R9 R7 first");
        drain_one(exp_burst(2'b01, 1'b0, 8), BASE + 32'd64, "R9 R7 second");
        @(negedge clk);
        chk(!wr_req, "R7 buffers empty", WORDS*32'(wr_req), '0);
        for (int n = 20; n < 28; n++) feed_frame(n, 1'b0);
        drain_one(exp_burst(2'b01, 1'b0, 20), BASE + 32'd128, "R9 after drop");
        for (int n = 40; n < 48; n++) feed_frame(n, 1'b0);
        drain_one(exp_burst(2'b01, 1'b0, 40), BASE, "R8 wrap");
        chk(bw_err, "R10 flag kept with no clear", WORDS*32'(bw_err), WORDS*32'(1));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule